// File: doc/BRIEF.md
# Auxiliary-Register Shift and Rotate Unit

This execution unit carries out a family of legacy 32-bit shift and rotate operations that work together with a private auxiliary register. Each operation takes a source operand, a shift count (from the low bits of a count operand or from a 5-bit immediate), the destination's current value and a pair of mask bounds. It produces the destination result, a carry update for the algebraic right shifts, and an optional condition-field update. Many of the operations also leave a rotated copy of the source in the auxiliary register. Later operations can merge that copy back in through a generated mask, so a sequence of operations can build shifts wider than one word.

A request is presented for one cycle with `valid_i` high. All outputs are registered and appear on the next rising edge, together with a one-cycle `done_o` pulse. Instruction decode, the register file and the rest of the flag handling sit outside the block.

Top module: `auxq_shifter`

## Requirements
- R1: On synchronous active-high reset, `done_o`, `res_o`, `aux_o`, `ca_we_o`, `ca_o`, `cr0_we_o` and `cr0_o` all become zero.
- R2: A request with `valid_i` high produces its results on the next rising edge with `done_o` high for that one cycle. In cycles without a request, `done_o` is low and `res_o` and `aux_o` keep their values.
- R3: The count n is `imm_cnt_i` when `use_imm_i` is 1, and `cnt_i[4:0]` otherwise. The extension flag is `cnt_i[5]` and is forced to 0 for immediate requests. A count of zero leaves every rotated value equal to the source.
- R4: Op 0 (left, extended): the result is src << n and the auxiliary register gets rotl(src,n). Op 1 (left, merge): the result is (rotl(src,n) & L) | (aux & ~L), with L = all-ones << n, and the auxiliary register gets rotl(src,n).
- R5: Op 2 (left, long merge): the auxiliary register is not written. With the extension flag set, the result is aux & L. With it clear, the result is (src << n) | (aux & ~L).
- R6: Op 3 (right, extended): the result is src >> n. Op 4 (right, merge): the result is (src >> n) | (aux & ~(all-ones >> n)). Both write rotr(src,n) to the auxiliary register.
- R7: Op 5 (algebraic right, extended): the result is src arithmetically shifted right by n. Op 6 (algebraic right, queued): the shift is by 31 when the extension flag is set and by n otherwise. Both write rotr(src,n) to the auxiliary register.
- R8: Only ops 5 and 6 raise `ca_we_o`. `ca_o` is 1 exactly when src is negative and a nonzero bit was shifted out. The bits shifted out are src & (~L) for op 5 and for op 6 with the flag clear, and all of src for op 6 with the flag set.
- R9: Op 7 (rotate with mask insert): the result is (rotl(src,n) & M) | (dst_old & ~M), and the auxiliary register is not written. Bit i of M is numbered from the MSB (bit 0 is the MSB). When from <= to, M covers bits from..to. When from > to, M wraps and covers bits >= from together with bits <= to.
- R10: When `rec_i` is set, `cr0_we_o` is 1 and `cr0_o` = {LT, GT, EQ, SO}, where LT, GT and EQ come from a signed compare of the result with zero and SO copies `so_i`. When `rec_i` is clear, `cr0_we_o` is 0.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code 0..7 |
| use_imm_i | input | 1 | Take the count from the immediate |
| imm_cnt_i | input | 5 | Immediate shift count |
| cnt_i | input | 6 | Low bits of the count operand, bit 5 is the extension flag |
| src_i | input | 32 | Source operand |
| dst_old_i | input | 32 | Current destination value |
| mask_from_i | input | 5 | Mask begin index, MSB-first |
| mask_to_i | input | 5 | Mask end index, MSB-first |
| rec_i | input | 1 | Record the condition field |
| so_i | input | 1 | Summary-overflow copy |
| done_o | output | 1 | Result valid pulse |
| res_o | output | 32 | Destination result |
| aux_o | output | 32 | Auxiliary register |
| ca_we_o | output | 1 | Carry update enable |
| ca_o | output | 1 | Carry value |
| cr0_we_o | output | 1 | Condition-field update enable |
| cr0_o | output | 4 | {LT, GT, EQ, SO} |

## Verification
Every operation is driven with counts of 0, 1, mid-range values and 31. Count 0 shows that no full-word shift artifact occurs, and count 31 reaches the last mask position. Sources with the sign bit set and with it clear separate arithmetic from logical fill. Shifted-out fields that are all zero or that hold a single one show whether carry depends on the lost bits and not only on the sign. The merge forms run after a known value has been placed in the auxiliary register, so a merge that takes the wrong side of the mask shows up. Mask bounds in order, equal and reversed separate the plain mask from the wrapped one.

// File: rtl/auxq_pkg.sv
package auxq_pkg;
  typedef enum logic [2:0] {
    OP_SHL_EXT  = 3'd0,
    OP_SHL_MRG  = 3'd1,
    OP_SHL_LONG = 3'd2,
    OP_SHR_EXT  = 3'd3,
    OP_SHR_MRG  = 3'd4,
    OP_SRA_EXT  = 3'd5,
    OP_SRA_Q    = 3'd6,
    OP_ROT_INS  = 3'd7
  } shop_e;

  function automatic logic op_writes_aux(shop_e op);
    return !(op == OP_SHL_LONG || op == OP_ROT_INS);
  endfunction

  function automatic logic op_sets_carry(shop_e op);
    return (op == OP_SRA_EXT || op == OP_SRA_Q);
  endfunction
endpackage

// File: rtl/auxq_rotator.sv
module auxq_rotator #(
  parameter int XLEN = 32,
  parameter bit LEFT = 1'b1,
  localparam int CW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] din,
  input  logic [CW-1:0]   amt,
  output logic [XLEN-1:0] dout
);
  logic [CW:0][XLEN-1:0] stg;
  assign stg[0] = din;

  for (genvar s = 0; s < CW; s++) begin : g_stage
    localparam int D = 1 << s;
    if (LEFT) begin : g_left
      assign stg[s+1] = amt[s] ? {stg[s][XLEN-1-D:0], stg[s][XLEN-1:XLEN-D]} : stg[s];
    end else begin : g_right
      assign stg[s+1] = amt[s] ? {stg[s][D-1:0], stg[s][XLEN-1:D]} : stg[s];
    end
  end

  assign dout = stg[CW];
endmodule

// File: rtl/auxq_maskgen.sv
module auxq_maskgen #(
  parameter int XLEN = 32,
  localparam int CW = $clog2(XLEN)
) (
  input  logic [CW-1:0]   from_idx,
  input  logic [CW-1:0]   to_idx,
  output logic [XLEN-1:0] mask
);
  logic wrap;
  assign wrap = from_idx > to_idx;

  // index i counts from the MSB
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    localparam logic [CW-1:0] IDX = CW'(i);
    logic ge_from, le_to;
    assign ge_from = IDX >= from_idx;
    assign le_to   = IDX <= to_idx;
    assign mask[XLEN-1-i] = wrap ? (ge_from | le_to) : (ge_from & le_to);
  end
endmodule

// File: rtl/auxq_datapath.sv
module auxq_datapath
  import auxq_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int CW = $clog2(XLEN)
) (
  input  shop_e           op,
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] dst_old,
  input  logic [XLEN-1:0] aux_q,
  input  logic [CW-1:0]   n,
  input  logic            ext,
  input  logic [CW-1:0]   from_idx,
  input  logic [CW-1:0]   to_idx,
  output logic [XLEN-1:0] res_nx,
  output logic [XLEN-1:0] aux_nx,
  output logic            aux_we,
  output logic            ca_nx,
  output logic            ca_we
);
  localparam logic [XLEN-1:0] ONES = '1;

  logic [XLEN-1:0] rot_l, rot_r, ins_mask;
  logic [XLEN-1:0] lmask, rmask, low_bits;
  logic signed [XLEN-1:0] sra_n;
  logic [XLEN-1:0] sra_q;
  logic            neg;

  auxq_rotator #(.XLEN(XLEN), .LEFT(1'b1)) u_rotl (.din(src), .amt(n), .dout(rot_l));
  auxq_rotator #(.XLEN(XLEN), .LEFT(1'b0)) u_rotr (.din(src), .amt(n), .dout(rot_r));
  auxq_maskgen #(.XLEN(XLEN)) u_mask (.from_idx(from_idx), .to_idx(to_idx), .mask(ins_mask));

  assign lmask    = ONES << n;
  assign rmask    = ONES >> n;
  assign low_bits = ~lmask;
  assign neg      = src[XLEN-1];
  assign sra_n    = $signed(src) >>> n;
  assign sra_q    = ext ? {XLEN{neg}} : sra_n;

  always_comb begin
    res_nx = '0;
    aux_nx = rot_r;
    aux_we = op_writes_aux(op);
    ca_we  = op_sets_carry(op);
    ca_nx  = 1'b0;
    unique case (op)
      OP_SHL_EXT: begin
        res_nx = src << n;
        aux_nx = rot_l;
      end
      OP_SHL_MRG: begin
        res_nx = (rot_l & lmask) | (aux_q & low_bits);
        aux_nx = rot_l;
      end
      OP_SHL_LONG: begin
        res_nx = ext ? (aux_q & lmask) : ((src << n) | (aux_q & low_bits));
      end
      OP_SHR_EXT: begin
        res_nx = src >> n;
      end
      OP_SHR_MRG: begin
        res_nx = (src >> n) | (aux_q & ~rmask);
      end
      OP_SRA_EXT: begin
        res_nx = sra_n;
        ca_nx  = neg & (|(src & low_bits));
      end
      OP_SRA_Q: begin
        res_nx = sra_q;
        ca_nx  = neg & (|(src & (ext ? ONES : low_bits)));
      end
      OP_ROT_INS: begin
        res_nx = (rot_l & ins_mask) | (dst_old & ~ins_mask);
      end
      default: res_nx = '0;
    endcase
  end
endmodule

// File: rtl/auxq_shifter.sv
module auxq_shifter
  import auxq_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int CW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [2:0]      op_i,
  input  logic            use_imm_i,
  input  logic [CW-1:0]   imm_cnt_i,
  input  logic [CW:0]     cnt_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] dst_old_i,
  input  logic [CW-1:0]   mask_from_i,
  input  logic [CW-1:0]   mask_to_i,
  input  logic            rec_i,
  input  logic            so_i,
  output logic            done_o,
  output logic [XLEN-1:0] res_o,
  output logic [XLEN-1:0] aux_o,
  output logic            ca_we_o,
  output logic            ca_o,
  output logic            cr0_we_o,
  output logic [3:0]      cr0_o
);
  logic [CW-1:0]   n;
  logic            ext;
  logic [XLEN-1:0] res_nx, aux_nx;
  logic            aux_we, ca_nx, ca_we;
  logic            lt, gt, eq;

  assign n   = use_imm_i ? imm_cnt_i : cnt_i[CW-1:0];
  assign ext = use_imm_i ? 1'b0 : cnt_i[CW];

  auxq_datapath #(.XLEN(XLEN)) u_dp (
    .op(shop_e'(op_i)), .src(src_i), .dst_old(dst_old_i), .aux_q(aux_o),
    .n(n), .ext(ext), .from_idx(mask_from_i), .to_idx(mask_to_i),
    .res_nx(res_nx), .aux_nx(aux_nx), .aux_we(aux_we),
    .ca_nx(ca_nx), .ca_we(ca_we)
  );

  assign lt = res_nx[XLEN-1];
  assign eq = (res_nx == '0);
  assign gt = !lt && !eq;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o   <= 1'b0;
      res_o    <= '0;
      aux_o    <= '0;
      ca_we_o  <= 1'b0;
      ca_o     <= 1'b0;
      cr0_we_o <= 1'b0;
      cr0_o    <= 4'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        res_o    <= res_nx;
        ca_we_o  <= ca_we;
        ca_o     <= ca_we & ca_nx;
        cr0_we_o <= rec_i;
        if (rec_i) cr0_o <= {lt, gt, eq, so_i};
        if (aux_we) aux_o <= aux_nx;
      end else begin
        ca_we_o  <= 1'b0;
        cr0_we_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/auxq_shifter_chk.sv
module auxq_shifter_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            valid_i,
  input logic [2:0]      op_i,
  input logic            rec_i,
  input logic            done_o,
  input logic [XLEN-1:0] res_o,
  input logic [XLEN-1:0] aux_o,
  input logic            ca_we_o,
  input logic            ca_o,
  input logic            cr0_we_o,
  input logic [3:0]      cr0_o
);
  assert_done_follows_R2: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> done_o);
  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!done_o && $stable(res_o) && $stable(aux_o)));
  assert_aux_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd2) |=> $stable(aux_o));
  assert_aux_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd7) |=> $stable(aux_o));
  assert_carry_ops_R8: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> (ca_we_o == ($past(op_i) == 3'd5 || $past(op_i) == 3'd6)));
  assert_carry_sign_R8: assert property (@(posedge clk) disable iff (rst)
    (ca_we_o && ca_o) |-> res_o[XLEN-1]);
  assert_cr0_enable_R10: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> (cr0_we_o == $past(rec_i)));
  assert_cr0_eq_R10: assert property (@(posedge clk) disable iff (rst)
    cr0_we_o |-> (cr0_o[1] == (res_o == '0) && $onehot(cr0_o[3:1])));
endmodule

bind auxq_shifter auxq_shifter_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .rec_i(rec_i),
  .done_o(done_o), .res_o(res_o), .aux_o(aux_o), .ca_we_o(ca_we_o),
  .ca_o(ca_o), .cr0_we_o(cr0_we_o), .cr0_o(cr0_o)
);

// File: tb/auxq_shifter_test.sv
`timescale 1ns/1ps
module auxq_shifter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic        use_imm_i = 1'b0;
  logic [4:0]  imm_cnt_i = '0;
  logic [5:0]  cnt_i = '0;
  logic [31:0] src_i = '0, dst_old_i = '0;
  logic [4:0]  mask_from_i = '0, mask_to_i = '0;
  logic        rec_i = 1'b0, so_i = 1'b0;
  logic        done_o, ca_we_o, ca_o, cr0_we_o;
  logic [31:0] res_o, aux_o;
  logic [3:0]  cr0_o;

  int errs = 0;
  int checks = 0;
  logic [31:0] m_aux = '0;

  always #2 clk = ~clk;

  auxq_shifter uut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .use_imm_i(use_imm_i),
    .imm_cnt_i(imm_cnt_i), .cnt_i(cnt_i), .src_i(src_i), .dst_old_i(dst_old_i),
    .mask_from_i(mask_from_i), .mask_to_i(mask_to_i), .rec_i(rec_i), .so_i(so_i),
    .done_o(done_o), .res_o(res_o), .aux_o(aux_o), .ca_we_o(ca_we_o), .ca_o(ca_o),
    .cr0_we_o(cr0_we_o), .cr0_o(cr0_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rotl(logic [31:0] x, logic [4:0] n);
    logic [63:0] t = {x, x} << n;
    return t[63:32];
  endfunction

  function automatic logic [31:0] rotr(logic [31:0] x, logic [4:0] n);
    logic [63:0] t = {x, x} >> n;
    return t[31:0];
  endfunction

  function automatic logic [31:0] be_mask(logic [4:0] f, logic [4:0] t);
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++) begin
      if (f <= t) m[31-i] = (i >= f) && (i <= t);
      else        m[31-i] = (i >= f) || (i <= t);
    end
    return m;
  endfunction

  task automatic run_op(string tag, logic [2:0] op, logic [31:0] rs, logic [5:0] rb,
                        logic [31:0] old, logic ui, logic [4:0] imm,
                        logic [4:0] f, logic [4:0] t, logic rec, logic so);
    logic [4:0]  n = ui ? imm : rb[4:0];
    logic        ext = ui ? 1'b0 : rb[5];
    logic [31:0] L = 32'hFFFF_FFFF << n;
    logic [31:0] R = 32'hFFFF_FFFF >> n;
    logic [31:0] sgn = rs[31] ? 32'hFFFF_FFFF : 32'h0;
    logic [31:0] sran = (rs >> n) | (sgn & ~R);
    logic [31:0] e = '0;
    logic        cwe = 1'b0, cv = 1'b0;
    logic [3:0]  ecr;
    case (op)
      3'd0: begin e = rs << n; m_aux = rotl(rs, n); end
      3'd1: begin e = (rotl(rs, n) & L) | (m_aux & ~L); m_aux = rotl(rs, n); end
      3'd2: e = ext ? (m_aux & L) : ((rs << n) | (m_aux & ~L));
      3'd3: begin e = rs >> n; m_aux = rotr(rs, n); end
      3'd4: begin e = (rs >> n) | (m_aux & ~R); m_aux = rotr(rs, n); end
      3'd5: begin e = sran; cwe = 1; cv = rs[31] && ((rs & ~L) != 0); m_aux = rotr(rs, n); end
      3'd6: begin e = ext ? sgn : sran; cwe = 1;
                  cv = rs[31] && ((rs & (ext ? 32'hFFFF_FFFF : ~L)) != 0); m_aux = rotr(rs, n); end
      default: e = (rotl(rs, n) & be_mask(f, t)) | (old & ~be_mask(f, t));
    endcase
    ecr = {e[31], !e[31] && e != 0, e == 0, so};
    @(negedge clk);
    valid_i = 1; op_i = op; src_i = rs; cnt_i = rb; dst_old_i = old;
    use_imm_i = ui; imm_cnt_i = imm; mask_from_i = f; mask_to_i = t; rec_i = rec; so_i = so;
    @(posedge clk); #1;
    valid_i = 0;
    chk("R2", {tag, " done"}, {31'b0, done_o}, 32'd1);
    chk(tag, "result", res_o, e);
    chk(tag, "aux", aux_o, m_aux);
    chk("R8", {tag, " ca_we"}, {31'b0, ca_we_o}, {31'b0, cwe});
    if (cwe) chk("R8", {tag, " ca"}, {31'b0, ca_o}, {31'b0, cv});
    chk("R10", {tag, " cr0_we"}, {31'b0, cr0_we_o}, {31'b0, rec});
    if (rec) chk("R10", {tag, " cr0"}, {28'b0, cr0_o}, {28'b0, ecr});
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (2) @(posedge clk);
    #1;
    m_aux = '0;
    chk("R1", "done", {31'b0, done_o}, 32'd0);
    chk("R1", "result", res_o, 32'd0);
    chk("R1", "aux", aux_o, 32'd0);
    chk("R1", "flags", {25'b0, ca_we_o, ca_o, cr0_we_o, cr0_o}, 32'd0);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic t_idle();
    logic [31:0] r0 = res_o, a0 = aux_o;
    @(negedge clk);
    src_i = 32'hDEAD_BEEF; op_i = 3'd0; cnt_i = 6'd7;
    @(posedge clk); #1;
    chk("R2", "idle done", {31'b0, done_o}, 32'd0);
    chk("R2", "idle result", res_o, r0);
    chk("R2", "idle aux", aux_o, a0);
  endtask

  task automatic t_left();
    run_op("R4", 3'd0, 32'h8000_0001, 6'd4, 0, 0, 0, 0, 0, 0, 0);
    run_op("R3", 3'd0, 32'h1234_5678, 6'd0, 0, 0, 0, 0, 0, 0, 0);
    run_op("R4", 3'd1, 32'hF0F0_1234, 6'd8, 0, 0, 0, 0, 0, 0, 0);
    run_op("R4", 3'd1, 32'h0000_0001, 6'd31, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_long();
    run_op("R4", 3'd0, 32'hA5A5_C3C3, 6'd12, 0, 0, 0, 0, 0, 0, 0);
    run_op("R5", 3'd2, 32'h0000_FFFF, 6'd8, 0, 0, 0, 0, 0, 0, 0);
    run_op("R5", 3'd2, 32'h0000_FFFF, 6'h28, 0, 0, 0, 0, 0, 0, 0);
    run_op("R5", 3'd2, 32'h1357_9BDF, 6'h20, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_right();
    run_op("R6", 3'd3, 32'h8765_4321, 6'd4, 0, 0, 0, 0, 0, 0, 0);
    run_op("R6", 3'd4, 32'hFFFF_0000, 6'd16, 0, 0, 0, 0, 0, 0, 0);
    run_op("R6", 3'd4, 32'h0F00_000F, 6'd0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_arith();
    run_op("R7", 3'd5, 32'h8000_0010, 6'd4, 0, 0, 0, 0, 0, 0, 0); // no lost ones: CA 0
    run_op("R8", 3'd5, 32'h8000_0018, 6'd4, 0, 0, 0, 0, 0, 0, 0); // lost one: CA 1
    run_op("R8", 3'd5, 32'h7000_00FF, 6'd4, 0, 0, 0, 0, 0, 0, 0); // positive: CA 0
    run_op("R7", 3'd6, 32'hC000_0000, 6'h25, 0, 0, 0, 0, 0, 0, 0); // flag: shift 31
    run_op("R8", 3'd6, 32'h8000_0000, 6'h20, 0, 0, 0, 0, 0, 0, 0); // flag: CA 1
    run_op("R8", 3'd6, 32'hFFFF_FF00, 6'd8, 0, 0, 0, 0, 0, 0, 0);  // CA 0
    run_op("R8", 3'd6, 32'hFFFF_FF00, 6'd9, 0, 0, 0, 0, 0, 0, 0);  // CA 1
  endtask

  task automatic t_insert();
    run_op("R9", 3'd7, 32'h0000_00FF, 6'd8, 32'h1111_1111, 0, 0, 16, 23, 0, 0);
    run_op("R9", 3'd7, 32'hFFFF_FFFF, 6'd0, 32'h0000_0000, 0, 0, 28, 3, 0, 0);
    run_op("R9", 3'd7, 32'h8000_0001, 6'h21, 32'h5555_5555, 0, 0, 31, 31, 0, 0);
    run_op("R9", 3'd7, 32'hABCD_EF01, 6'd0, 32'h0, 0, 0, 0, 31, 0, 0);
  endtask

  task automatic t_imm();
    run_op("R3", 3'd6, 32'h8000_0000, 6'h3F, 0, 1, 5'd1, 0, 0, 0, 0);
    run_op("R3", 3'd3, 32'hF000_0000, 6'd20, 0, 1, 5'd28, 0, 0, 0, 0);
  endtask

  task automatic t_cr0();
    run_op("R10", 3'd3, 32'h0000_000F, 6'd4, 0, 0, 0, 0, 0, 1, 1);
    run_op("R10", 3'd0, 32'h0000_0001, 6'd31, 0, 0, 0, 0, 0, 1, 0);
    run_op("R10", 3'd3, 32'h8000_0000, 6'd1, 0, 0, 0, 0, 0, 1, 1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #(4 * 200000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_left();
    t_idle();
    t_long();
    t_right();
    t_arith();
    t_insert();
    t_idle();
    t_imm();
    t_cr0();
    t_reset();
    summary();
    $finish;
  end
endmodule